// File: doc/BRIEF.md
# Audio Transmitter Control and Interrupt Unit

This unit holds the control word of a serial digital audio transmitter. A host bus writes the word with a one-cycle write strobe and reads it back on a combinational read port. The low six bits have a function. The upper bits read as zero and ignore what is written to them.

The unit combines three interrupt enables with status flags from the transmitter core to drive one level-sensitive interrupt request. The flags are data register empty, underrun, and block boundary. The unit also holds a 2-bit clock source field, which is locked while the transmitter runs. A one-shot "force block restart" bit tells the frame sequencer to open its next frame with the block-start preamble. The sequencer clears that bit by pulsing a "block started" input.

All ports are plain control and status pins. No data stream passes through the unit, so it has no valid/ready handshake. A write takes effect at the clock edge where the strobe is sampled. The read data, the interrupt request and the outputs to the core follow the register with no further delay.

Top module: `atx_ctl_irq`

## Requirements
- R1: On synchronous reset (`rst` high) the control word clears to all zeros. Then `rd_data` is 0, `clk_sel` is 0, `force_block` is 0, and `irq` is 0 whatever the status flags are.
- R2: A write with `wr_en` high loads bits 2:0 from `wr_data` on the next rising edge. `rd_data[2:0]` then returns those bits.
- R3: When bit 0 (data-empty interrupt enable) is 1 and `st_empty` is 1, `irq` is 1.
- R4: When bit 1 (underrun interrupt enable) is 1 and `st_underrun` is 1, `irq` is 1.
- R5: Bit 2 (block interrupt enable) raises `irq` only when both `st_block` and `st_empty` are 1. `st_block` alone does not raise it.
- R6: `irq` is a level, not a pulse. It is exactly the OR of the three gated conditions for every enable and flag combination. It stays high while the condition holds and drops when the flag or the enable clears.
- R7: With `tx_enabled` low, a write loads bits 4:3 into the clock select field. `clk_sel` and `rd_data[4:3]` then show it. The codes are: 00 core clock at 1024×fs, 01 external pin at 256×fs, 10 external pin at 384×fs, 11 external pin at 512×fs.
- R8: With `tx_enabled` high, a write leaves bits 4:3 unchanged. The other fields of the same write still load.
- R9: Writing 1 to bit 5 sets the force block restart bit, and `force_block` equals that bit. Writing 0 to bit 5 does not clear it.
- R10: A one-cycle `blk_started` pulse clears bit 5 on that rising edge, so `force_block` is 0 afterwards.
- R11: If a write with bit 5 set falls in the same cycle as `blk_started`, the write wins and bit 5 stays 1.
- R12: Bits 23:6 always read 0, even after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 24 | Host write data |
| rd_data | output | 24 | Current control word, upper bits zero |
| tx_enabled | input | 1 | Transmitter running; locks the clock select field |
| blk_started | input | 1 | One-cycle pulse from the sequencer when a new block begins |
| st_empty | input | 1 | Core status: audio data register empty |
| st_underrun | input | 1 | Core status: underrun error |
| st_block | input | 1 | Core status: block boundary reached |
| irq | output | 1 | Level interrupt request |
| clk_sel | output | 2 | Clock source code to the core |
| force_block | output | 1 | Start next frame with block-start preamble |

## Verification
The interrupt logic is swept over all 64 pairs of enable bits and status flags. This separates a correct gate from one that omits the data-empty term of the block interrupt or wires an enable to the wrong flag.

All four clock codes are written while the transmitter is stopped, and a different code is written while it runs. This separates the lock from a field that always loads or never loads.

The restart bit is driven through four cases: a set, a zero write, a clear by the sequencer pulse, and a set in the same cycle as that pulse. The last case shows whether the write or the clear has priority.

// File: rtl/atx_ctl_pkg.sv
package atx_ctl_pkg;

  localparam int CTL_W       = 24;  // host word width
  localparam int NUM_IRQ     = 3;   // interrupt sources
  localparam int USED_W      = 6;   // bits that hold state

  typedef enum logic [1:0] {
    CS_CORE_1024 = 2'b00,
    CS_PIN_256   = 2'b01,
    CS_PIN_384   = 2'b10,
    CS_PIN_512   = 2'b11
  } clk_src_e;

  // Packed layout equals the host bit positions: [5] force, [4:3] clock, [2:0] enables
  typedef struct packed {
    logic                 force_blk;
    clk_src_e             clk_src;
    logic [NUM_IRQ-1:0]   irq_en;
  } ctl_reg_t;

  // Interrupt enable indices inside irq_en
  localparam int IE_EMPTY = 0;
  localparam int IE_UNDR  = 1;
  localparam int IE_BLOCK = 2;

endpackage

// File: rtl/atx_ctl_reg.sv
module atx_ctl_reg
  import atx_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  ctl_reg_t wr_val,
  input  logic     tx_enabled,
  input  logic     blk_started,
  output ctl_reg_t ctl_q
);

  ctl_reg_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.irq_en = wr_val.irq_en;
      if (!tx_enabled)
        ctl_d.clk_src = wr_val.clk_src;
    end
    // host set has priority over the sequencer clear
    if (wr_en && wr_val.force_blk)
      ctl_d.force_blk = 1'b1;
    else if (blk_started)
      ctl_d.force_blk = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

  // R8: clock field frozen while transmitter runs
  a_r8_sel_locked: assert property (@(posedge clk) disable iff (rst)
    tx_enabled |=> $stable(ctl_q.clk_src));

  // R7: clock field loads when stopped
  a_r7_sel_loads: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !tx_enabled) |=> ctl_q.clk_src == $past(wr_val.clk_src));

  // R11: a set write wins over a same-cycle clear
  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_val.force_blk) |=> ctl_q.force_blk);

  // R10: the sequencer pulse clears the bit
  a_r10_self_clear: assert property (@(posedge clk) disable iff (rst)
    (blk_started && !(wr_en && wr_val.force_blk)) |=> !ctl_q.force_blk);

  // R9: only the sequencer can clear the bit
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.force_blk && !blk_started) |=> ctl_q.force_blk);

endmodule

// File: rtl/atx_irq_gate.sv
module atx_irq_gate #(
  parameter int N = 3
) (
  input  logic [N-1:0] en,
  input  logic [N-1:0] cond,
  output logic         irq
);

  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign gated[i] = en[i] & cond[i];
  end

  assign irq = |gated;

endmodule

// File: rtl/atx_ctl_irq.sv
module atx_ctl_irq
  import atx_ctl_pkg::*;
#(
  parameter int CTL_BITS = CTL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CTL_BITS-1:0] wr_data,
  output logic [CTL_BITS-1:0] rd_data,
  input  logic                tx_enabled,
  input  logic                blk_started,
  input  logic                st_empty,
  input  logic                st_underrun,
  input  logic                st_block,
  output logic                irq,
  output logic [1:0]          clk_sel,
  output logic                force_block
);

  localparam int RSV_W = CTL_BITS - USED_W;

  ctl_reg_t           ctl_q;
  ctl_reg_t           wr_val;
  logic [NUM_IRQ-1:0] irq_cond;

  assign wr_val = ctl_reg_t'(wr_data[USED_W-1:0]);

  atx_ctl_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_val      (wr_val),
    .tx_enabled  (tx_enabled),
    .blk_started (blk_started),
    .ctl_q       (ctl_q)
  );

  assign irq_cond[IE_EMPTY] = st_empty;
  assign irq_cond[IE_UNDR]  = st_underrun;
  assign irq_cond[IE_BLOCK] = st_block & st_empty;

  atx_irq_gate #(.N(NUM_IRQ)) u_gate (
    .en   (ctl_q.irq_en),
    .cond (irq_cond),
    .irq  (irq)
  );

  assign rd_data     = {{RSV_W{1'b0}}, ctl_q};
  assign clk_sel     = ctl_q.clk_src;
  assign force_block = ctl_q.force_blk;

  // R3: empty flag with its enable requests
  a_r3_empty_irq: assert property (@(posedge clk) disable iff (rst)
    (st_empty && rd_data[0]) |-> irq);

  // R4: underrun flag with its enable requests
  a_r4_underrun_irq: assert property (@(posedge clk) disable iff (rst)
    (st_underrun && rd_data[1]) |-> irq);

  // R5: block-only request needs both flags
  a_r5_block_needs_empty: assert property (@(posedge clk) disable iff (rst)
    (irq && !rd_data[0] && !rd_data[1]) |-> (st_block && st_empty));

  // R12: reserved bits never take written ones
  a_r12_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (|wr_data[CTL_BITS-1:USED_W])) |=> rd_data[CTL_BITS-1:USED_W] == '0);

endmodule

// File: tb/sim_atx_ctl_irq.sv
module sim_atx_ctl_irq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_data;
  logic        tx_enabled = 1'b0;
  logic        blk_started = 1'b0;
  logic        st_empty = 1'b0;
  logic        st_underrun = 1'b0;
  logic        st_block = 1'b0;
  logic        irq;
  logic [1:0]  clk_sel;
  logic        force_block;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  atx_ctl_irq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tx_enabled(tx_enabled), .blk_started(blk_started), .st_empty(st_empty),
    .st_underrun(st_underrun), .st_block(st_block), .irq(irq),
    .clk_sel(clk_sel), .force_block(force_block)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one-cycle write; optional sequencer pulse in the same cycle; returns at next negedge
  task automatic wr(input logic [23:0] d, input logic blk);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; blk_started = blk;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; blk_started = 1'b0;
  endtask

  task automatic pulse_blk();
    @(negedge clk);
    blk_started = 1'b1;
    @(negedge clk);
    blk_started = 1'b0;
  endtask

  task automatic set_st(input logic [2:0] s);
    {st_block, st_underrun, st_empty} = s;
    #2;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic exp_irq;
    // R1: reset with all flags raised
    set_st(3'b111);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 24'h0);
    chk("R1 irq", {23'h0, irq}, 24'h0);
    chk("R1 clk_sel", {22'h0, clk_sel}, 24'h0);
    chk("R1 force_block", {23'h0, force_block}, 24'h0);
    set_st(3'b000);

    // R12: write all ones, upper bits read zero
    wr(24'hFFFFFF, 1'b0);
    chk("R12 reserved", {6'h0, rd_data[23:6]}, 24'h0);
    chk("R12 used bits", rd_data, 24'h00003F);
    pulse_blk();
    wr(24'h000000, 1'b0);
    chk("R12 cleared", rd_data, 24'h0);

    // R2 and R6: full sweep of enables against flags
    for (int e = 0; e < 8; e++) begin
      wr(24'(e), 1'b0);
      chk("R2 enable readback", rd_data, 24'(e));
      for (int s = 0; s < 8; s++) begin
        set_st(3'(s));
        exp_irq = (e[0] & s[0]) | (e[1] & s[1]) | (e[2] & s[2] & s[0]);
        chk("R6 irq sweep", {23'h0, irq}, {23'h0, exp_irq});
      end
    end

    // R3, R4, R5 directed
    wr(24'h000001, 1'b0); set_st(3'b001);
    chk("R3 empty irq", {23'h0, irq}, 24'h1);
    wr(24'h000002, 1'b0); set_st(3'b010);
    chk("R4 underrun irq", {23'h0, irq}, 24'h1);
    wr(24'h000004, 1'b0); set_st(3'b100);
    chk("R5 block alone", {23'h0, irq}, 24'h0);
    set_st(3'b101);
    chk("R5 block with empty", {23'h0, irq}, 24'h1);

    // R6: level holds over cycles, drops with enable
    wr(24'h000001, 1'b0); set_st(3'b001);
    repeat (3) @(negedge clk);
    chk("R6 level held", {23'h0, irq}, 24'h1);
    wr(24'h000000, 1'b0);
    chk("R6 enable cleared", {23'h0, irq}, 24'h0);
    set_st(3'b000);

    // R7: all clock codes while stopped
    tx_enabled = 1'b0;
    for (int c = 0; c < 4; c++) begin
      wr(24'(c << 3), 1'b0);
      chk("R7 clk_sel", {22'h0, clk_sel}, 24'(c));
      chk("R7 readback", {22'h0, rd_data[4:3]}, 24'(c));
    end

    // R8: locked while running, enables still load
    wr(24'h000008, 1'b0);
    tx_enabled = 1'b1;
    wr(24'h000015, 1'b0);  // code 10, enables 101
    chk("R8 clk_sel held", {22'h0, clk_sel}, 24'h1);
    chk("R8 enables load", {21'h0, rd_data[2:0]}, 24'h5);
    tx_enabled = 1'b0;

    // R9: set, zero write keeps
    wr(24'h000020, 1'b0);
    chk("R9 set", {23'h0, force_block}, 24'h1);
    wr(24'h000000, 1'b0);
    chk("R9 zero write keeps", {23'h0, force_block}, 24'h1);
    chk("R9 readback", {23'h0, rd_data[5]}, 24'h1);

    // R10: sequencer clears
    pulse_blk();
    chk("R10 self clear", {23'h0, force_block}, 24'h0);

    // R11: set in same cycle as pulse
    wr(24'h000020, 1'b1);
    chk("R11 write wins", {23'h0, force_block}, 24'h1);
    pulse_blk();
    chk("R10 clear after tie", {23'h0, force_block}, 24'h0);

    done = 1'b1;
    summary();
  end

endmodule